// File: doc/BRIEF.md
# Trigger-Timed Register Bank Selector

This block drives the control word of one receiver tuner from one of two stored banks, bank 0 and bank 1. A two-bit operating mode decides which bank is used. Two static modes fix the choice. Two timed modes open a window on bank 1. The window starts when a rising edge arrives on an external trigger line or on a once-per-second pulse line. After the edge the block waits a programmed delay, holds bank 1 for a programmed interval and then returns to bank 0. All timing counts cycles of the 10 MHz reference clock, which also clocks the block, so bank changes stay coherent with the reference.

Software loads both banks, the mode, the delay and the interval through a simple write port. A tuner pair uses two independent instances, each with its own mode. The selected-bank flag and the control word are both registered. Each bank change therefore appears on one clock edge with no glitches.

Top module: `tbs_bank_select`

## Requirements
- R1: After reset both banks, the mode, the delay and the interval are zero, and `ctrl_out` and `bank_sel` are 0.
- R2: Mode value 0 drives bank 0 and mode value 1 drives bank 1 on `ctrl_out`, with `bank_sel` equal to the bank number. In these modes edges on `trig_in` and `pps_in` have no effect.
- R3: A write (`wr_en` high at a rising edge) to address 0 loads bank 0 from `wr_data[CW-1:0]`. Address 1 loads bank 1 from the same bits. Address 2 loads the mode from `wr_data[1:0]`. Address 3 loads the delay and address 4 loads the interval, each from `wr_data[TW-1:0]`. Writes to addresses 5 to 7 change nothing.
- R4: In mode 2, let k be the first rising clock edge that samples `trig_in` high after sampling it low. Bank 1 is driven from edge k+3+delay for exactly `interval` edges. Outside that window bank 0 is driven.
- R5: Mode 3 behaves as R4 with `pps_in` as the start source. Mode 3 ignores `trig_in`, and mode 2 ignores `pps_in`.
- R6: In the timed modes, an interval of zero means bank 1 is never driven.
- R7: A new start edge that arrives while a window is pending or active restarts the timing. Bank 0 is driven until the new delay has elapsed.
- R8: A mode write cancels any pending or active window, and this cancel takes priority over a start edge applied at the same clock edge. The outputs follow the new mode from the second rising edge after the write.
- R9: A write to the bank that is currently driving the outputs appears on `ctrl_out` at the second rising edge after the write.
- R10: `ctrl_out` always equals the bank that `bank_sel` names, and both change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | DW (max of CW, TW = 24) | Write data |
| trig_in | input | 1 | External trigger, asynchronous |
| pps_in | input | 1 | Once-per-second pulse, asynchronous |
| ctrl_out | output | CW (16) | Control word to tuner hardware |
| bank_sel | output | 1 | Bank currently driven (0 or 1) |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a mode write and a synchronized start edge. The second pair is a write to bank 1 and the rising edge of the window that starts driving bank 1. The bench places the write exactly on the edge where the synchronized trigger restarts the counter, and it also places bank writes inside open windows. A cycle model built from R4, R7, R8 and R9 then judges whether the cancel took priority and which bank value reached the output on each edge. Random segments mix retriggers, short delays and zero intervals, so these coincidences also happen without being planned.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
   typedef enum logic [1:0] {
      MODE_FIX0 = 2'd0,
      MODE_FIX1 = 2'd1,
      MODE_TRIG = 2'd2,
      MODE_PPS  = 2'd3
   } tbs_mode_e;

   localparam int ADDR_BANK0    = 0;
   localparam int ADDR_BANK1    = 1;
   localparam int ADDR_MODE     = 2;
   localparam int ADDR_DELAY    = 3;
   localparam int ADDR_INTERVAL = 4;
   localparam int NUM_REGS      = 5;
   localparam int NUM_SRC       = 2;
   localparam int SRC_TRIG      = 0;
   localparam int SRC_PPS       = 1;
endpackage

// File: rtl/tbs_sync_edge.sv
module tbs_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tbs_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

   assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tbs_regs.sv
module tbs_regs
   import tbs_pkg::*;
#(
   parameter int CW = 16,
   parameter int TW = 24,
   parameter int AW = 3,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [CW-1:0] bank0_o,
   output logic [CW-1:0] bank1_o,
   output tbs_mode_e     mode_o,
   output logic [TW-1:0] delay_o,
   output logic [TW-1:0] interval_o,
   output logic          mode_wr_o
);
   if ((1 << AW) < NUM_REGS) begin : g_bad_aw
      $error("tbs_regs: AW too small for the register set");
   end
   if (DW < CW || DW < TW) begin : g_bad_dw
      $error("tbs_regs: DW narrower than a register");
   end

   logic [NUM_REGS-1:0] hit;
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
      assign hit[r] = wr_en && (wr_addr == AW'(r));
   end

   assign mode_wr_o = hit[ADDR_MODE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank0_o    <= '0;
         bank1_o    <= '0;
         mode_o     <= MODE_FIX0;
         delay_o    <= '0;
         interval_o <= '0;
      end else begin
         if (hit[ADDR_BANK0])    bank0_o    <= wr_data[CW-1:0];
         if (hit[ADDR_BANK1])    bank1_o    <= wr_data[CW-1:0];
         if (hit[ADDR_MODE])     mode_o     <= tbs_mode_e'(wr_data[1:0]);
         if (hit[ADDR_DELAY])    delay_o    <= wr_data[TW-1:0];
         if (hit[ADDR_INTERVAL]) interval_o <= wr_data[TW-1:0];
      end
   end

   assert_onehot_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/tbs_window.sv
module tbs_window #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          cancel,
   input  logic [TW-1:0] delay,
   input  logic [TW-1:0] interval,
   output logic          win_o,
   output logic          running_o
);
   localparam int SW = TW + 1;

   logic [SW-1:0] cnt_q;
   logic [SW-1:0] span;
   logic          run_q;

   assign span = {1'b0, delay} + {1'b0, interval};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cancel) begin
         run_q <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q >= span) run_q <= 1'b0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign win_o     = run_q && (cnt_q >= {1'b0, delay}) && (cnt_q < span);
   assign running_o = run_q;

   assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !running_o);
   assert_restart_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !cancel) |=> running_o);
endmodule

// File: rtl/tbs_bank_select.sv
module tbs_bank_select
   import tbs_pkg::*;
#(
   parameter int CW          = 16,
   parameter int TW          = 24,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2,
   localparam int DW         = (CW > TW) ? CW : TW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          trig_in,
   input  logic          pps_in,
   output logic [CW-1:0] ctrl_out,
   output logic          bank_sel
);
   if (CW < 1 || TW < 1) begin : g_bad_width
      $error("tbs_bank_select: widths must be positive");
   end

   logic [CW-1:0] bank0_q, bank1_q;
   tbs_mode_e     mode_q;
   logic [TW-1:0] delay_q, interval_q;
   logic          mode_wr;

   tbs_regs #(.CW(CW), .TW(TW), .AW(AW), .DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .bank0_o   (bank0_q),
      .bank1_o   (bank1_q),
      .mode_o    (mode_q),
      .delay_o   (delay_q),
      .interval_o(interval_q),
      .mode_wr_o (mode_wr)
   );

   logic [NUM_SRC-1:0] src_async, src_rise;
   assign src_async[SRC_TRIG] = trig_in;
   assign src_async[SRC_PPS]  = pps_in;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      tbs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(src_async[s]),
         .rise_o  (src_rise[s])
      );
   end

   logic restart;
   always_comb begin
      unique case (mode_q)
         MODE_TRIG: restart = src_rise[SRC_TRIG];
         MODE_PPS:  restart = src_rise[SRC_PPS];
         default:   restart = 1'b0;
      endcase
   end

   logic win, running;
   tbs_window #(.TW(TW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .cancel   (mode_wr),
      .delay    (delay_q),
      .interval (interval_q),
      .win_o    (win),
      .running_o(running)
   );

   logic sel_next;
   always_comb begin
      unique case (mode_q)
         MODE_FIX0: sel_next = 1'b0;
         MODE_FIX1: sel_next = 1'b1;
         default:   sel_next = win;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_sel <= 1'b0;
         ctrl_out <= '0;
      end else begin
         bank_sel <= sel_next;
         ctrl_out <= sel_next ? bank1_q : bank0_q;
      end
   end

   assert_fix0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_FIX0) |=> !bank_sel);
   assert_fix1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_FIX1) |=> bank_sel);
   assert_zero_interval_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && interval_q == '0) |=> !bank_sel);
   assert_retrig_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !mode_wr && !wr_en && delay_q != '0) |=> !win);
   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && !running && !restart) |=> !bank_sel);
   assert_consistent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_sel) |-> (ctrl_out == $past(bank1_q)));
endmodule

// File: tb/sim_tbs_bank_select.sv
module sim_tbs_bank_select;
   localparam int CW = 16;
   localparam int TW = 24;
   localparam int AW = 3;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          trig_in = 1'b0;
   logic          pps_in = 1'b0;
   logic [CW-1:0] ctrl_out;
   logic          bank_sel;

   always #4 clk = ~clk;

   tbs_bank_select #(.CW(CW), .TW(TW), .AW(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trig_in(trig_in), .pps_in(pps_in),
      .ctrl_out(ctrl_out), .bank_sel(bank_sel)
   );

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // bench model built from the requirements
   logic [CW-1:0] m_b0, m_b1;
   logic [1:0]    m_mode;
   int            m_delay, m_iv, m_cnt;
   bit            m_run;
   bit            t1, t2, t3, p1, p2, p3;
   bit            exp_sel;
   logic [CW-1:0] exp_out;

   function automatic bit model_win(bit run, int cnt, int d, int iv);
      return run && cnt >= d && cnt < d + iv;
   endfunction

   task automatic model_reset();
      m_b0 = '0; m_b1 = '0; m_mode = 2'd0; m_delay = 0; m_iv = 0;
      m_cnt = 0; m_run = 0; t1 = 0; t2 = 0; t3 = 0; p1 = 0; p2 = 0; p3 = 0;
      exp_sel = 0; exp_out = '0;
   endtask

   task automatic model_edge(bit we, int addr, logic [DW-1:0] d, bit t, bit p);
      bit w, tr, pr, rs;
      w = model_win(m_run, m_cnt, m_delay, m_iv);
      exp_sel = (m_mode == 2'd1) ? 1'b1 : (m_mode[1] ? w : 1'b0);
      exp_out = exp_sel ? m_b1 : m_b0;
      tr = t2 && !t3;
      pr = p2 && !p3;
      rs = (m_mode == 2'd2 && tr) || (m_mode == 2'd3 && pr);
      if (we && addr == 2) m_run = 0;
      else if (rs) begin m_cnt = 0; m_run = 1; end
      else if (m_run) begin
         if (m_cnt >= m_delay + m_iv) m_run = 0;
         else m_cnt++;
      end
      if (we) begin
         case (addr)
            0: m_b0 = d[CW-1:0];
            1: m_b1 = d[CW-1:0];
            2: m_mode = d[1:0];
            3: m_delay = int'(d);
            4: m_iv = int'(d);
            default: ;
         endcase
      end
      t3 = t2; t2 = t1; t1 = t;
      p3 = p2; p2 = p1; p1 = p;
   endtask

   task automatic check_out();
      checks++;
      if (bank_sel !== exp_sel || ctrl_out !== exp_out) begin
         errors++;
         $display("FAIL %s: bank_sel=%0b ctrl_out=%h expected bank_sel=%0b ctrl_out=%h",
                  cur_req, bank_sel, ctrl_out, exp_sel, exp_out);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(bit we, int addr, logic [DW-1:0] d, bit t, bit p);
      wr_en = we; wr_addr = AW'(addr); wr_data = d; trig_in = t; pps_in = p;
      @(posedge clk);
      model_edge(we, addr, d, t, p);
      @(negedge clk);
      check_out();
   endtask

   task automatic wr(int addr, logic [DW-1:0] d);
      cyc(1, addr, d, trig_in, pps_in);
   endtask

   task automatic idle(int n, bit t, bit p);
      for (int i = 0; i < n; i++) cyc(0, 0, '0, t, p);
   endtask

   task automatic pulse_trig(int hi);
      idle(hi, 1, pps_in);
      trig_in = 0;
   endtask

   task automatic pulse_pps(int hi);
      idle(hi, trig_in, 1);
      pps_in = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check_out();
      rst_n = 1'b1;
      idle(2, 0, 0);

      cur_req = "R3";
      wr(0, 24'h00A5A5);
      wr(1, 24'h005A5A);
      idle(2, 0, 0);
      wr(2, 24'd1);
      idle(2, 0, 0);
      wr(5, 24'h00FFFF);
      wr(6, 24'h000003);
      wr(7, 24'h001234);
      idle(3, 0, 0);

      cur_req = "R2";
      wr(2, 24'd0);
      pulse_trig(3);
      pulse_pps(2);
      idle(10, 0, 0);
      wr(2, 24'd1);
      pulse_pps(3);
      pulse_trig(2);
      idle(10, 0, 0);

      cur_req = "R4";
      wr(3, 24'd5);
      wr(4, 24'd4);
      wr(2, 24'd2);
      idle(2, 0, 0);
      pulse_trig(3);
      idle(20, 0, 0);
      wr(3, 24'd0);
      pulse_trig(1);
      idle(12, 0, 0);

      cur_req = "R5";
      wr(3, 24'd3);
      wr(4, 24'd6);
      wr(2, 24'd3);
      pulse_trig(2);
      idle(12, 0, 0);
      pulse_pps(2);
      idle(16, 0, 0);
      wr(2, 24'd2);
      pulse_pps(2);
      idle(16, 0, 0);

      cur_req = "R6";
      wr(4, 24'd0);
      pulse_trig(2);
      idle(16, 0, 0);

      cur_req = "R7";
      wr(3, 24'd4);
      wr(4, 24'd8);
      pulse_trig(1);
      idle(8, 0, 0);
      pulse_trig(1);
      idle(2, 0, 0);
      pulse_trig(1);
      idle(20, 0, 0);

      cur_req = "R8";
      pulse_trig(1);
      idle(7, 0, 0);
      wr(2, 24'd2);
      idle(14, 0, 0);
      pulse_trig(1);
      idle(1, 0, 0);
      wr(2, 24'd2);
      idle(16, 0, 0);

      cur_req = "R9";
      pulse_trig(1);
      idle(8, 0, 0);
      wr(1, 24'h00C3C3);
      idle(2, 0, 0);
      wr(1, 24'h003C3C);
      idle(12, 0, 0);
      wr(0, 24'h00BEEF);
      idle(4, 0, 0);

      cur_req = "R10";
      for (int seg = 0; seg < 400; seg++) begin
         int k;
         k = int'($urandom_range(0, 9));
         case (k)
            0: wr(0, DW'($urandom));
            1: wr(1, DW'($urandom));
            2: wr(2, DW'($urandom_range(0, 3)));
            3: wr(3, DW'($urandom_range(0, 12)));
            4: wr(4, DW'($urandom_range(0, 12)));
            5, 6: pulse_trig(int'($urandom_range(1, 4)));
            7: pulse_pps(int'($urandom_range(1, 4)));
            default: idle(int'($urandom_range(1, 20)), 0, 0);
         endcase
      end
      idle(30, 0, 0);

      summary();
      $finish;
   end
endmodule